// File: doc/BRIEF.md
# Multichannel Sample Packer with Event Tagging

This block sits between a bank of converters that sample together and a 32-bit synchronous FIFO write port. On each sample strobe it takes the results of all channels, widens each one to 16 bits and packs two of them into each 32-bit word. It has three packing modes. Pair mode writes one chosen pair of adjacent channels. Scan mode writes every active channel as a run of consecutive words. Solo mode packs two consecutive samples of channel 0 into one word.

An active-low event input can arrive at any time, with no relation to the clock. It is synchronized and then tags the words it covers by forcing bit 31. The number of active channels in scan mode is set in groups of GRP channels, counted from channel 0. If a scan strobe arrives while the previous scan is still being written out, that scan is dropped and a sticky flag is raised.

Top module: `sample_packer`

## Requirements
- R1: Each written word puts the lower-numbered channel (or earlier sample) in bits 15:0 and the next channel (or later sample) in bits 31:16.
- R2: Each RES-bit sample is right-justified in its 16-bit half. The bits above RES copy the sample's top bit when BIPOLAR=1 and are zero when BIPOLAR=0.
- R3: With pack_mode 0 (and also 3), a strobe with pair_sel=p writes exactly one word holding channels 2p and 2p+1. wr_en is high in the cycle after the strobe.
- R4: With pack_mode 1, a strobe writes the channel pairs (0,1),(2,3),... in ascending order on consecutive cycles, starting the cycle after the strobe. All words use the values present at the strobe. A later scan begins again at pair (0,1).
- R5: In scan mode the active channel count is (grp_sel+1)*GRP, capped at NCH. This gives half that many words per scan.
- R6: With pack_mode 2, the first strobe after entering the mode writes nothing and holds channel 0. The next strobe writes one word with the held sample low and the new channel-0 sample high. This pattern then alternates.
- R7: mark_n is synchronized through two flops. When mark_n has been low for at least three clocks before a strobe, every word produced from that strobe has bit 31 set. Otherwise bit 31 is the high sample's bit 15. In solo mode, a marker seen at either of the two strobes tags the word.
- R8: In scan mode, a strobe that arrives while words of the previous scan are still pending is dropped: no words are written for it. It also sets overrun, which stays high until reset. A strobe that comes exactly one scan length after the accepted one is taken normally.
- R9: After reset, wr_en=0, wr_data=0 and overrun=0, and the solo-mode hold is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb | input | 1 | One-cycle sample strobe |
| smp_data | input | NCH*RES | All channel samples, channel 0 in the lowest RES bits |
| pack_mode | input | 2 | 0 pair, 1 scan, 2 solo, 3 pair |
| pair_sel | input | log2(NCH/2) | Pair index used in pair mode |
| grp_sel | input | log2(NCH/GRP), min 1 | Active channel groups minus one |
| mark_n | input | 1 | Asynchronous active-low event marker |
| wr_data | output | 32 | FIFO write data |
| wr_en | output | 1 | FIFO write enable |
| overrun | output | 1 | Sticky scan-overrun flag |

## Verification
The assertions assume that smp_stb is a single-cycle pulse synchronous to clk. They also assume that pack_mode and grp_sel are held steady while a scan is still writing words. The index bound and the word count both depend on grp_sel not changing mid-scan. The stimulus changes mode and group count only after the expected-word queue has drained. It changes the channel buses right after each scan strobe, which shows that later words come from the captured copy. It holds the marker for several clocks before and after each tagged strobe, so the synchronizer delay never lands on a strobe edge.

// File: rtl/packer_pkg.sv
package packer_pkg;
  typedef enum logic [1:0] {
    PK_PAIR = 2'd0,
    PK_SCAN = 2'd1,
    PK_SOLO = 2'd2,
    PK_ALT  = 2'd3
  } pack_mode_e;

  // High half in 31:16, low half in 15:0; the marker forces bit 31 (R1, R7)
  function automatic logic [31:0] make_word(logic [15:0] lo, logic [15:0] hi, logic mk);
    return {hi[15] | mk, hi[14:0], lo};
  endfunction
endpackage

// File: rtl/mark_sync.sv
module mark_sync (
  input  logic clk,
  input  logic rst,
  input  logic mark_n_i,
  output logic mark_o
);
  logic s1, s2;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else begin
      s1 <= ~mark_n_i;
      s2 <= s1;
    end
  end

  assign mark_o = s2;

  // R7: a synchronized marker always reflects the pin two edges earlier
  assert_mark_latency_R7: assert property (@(posedge clk) disable iff (rst)
    mark_o |-> $past(!mark_n_i, 2));
endmodule

// File: rtl/chan_fmt.sv
module chan_fmt #(
  parameter int NCH     = 16,
  parameter int RES     = 12,
  parameter bit BIPOLAR = 1'b1
) (
  input  logic [NCH-1:0][RES-1:0] raw_i,
  output logic [NCH-1:0][15:0]    ext_o
);
  localparam int PAD = 16 - RES;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    if (PAD == 0) begin : g_full
      assign ext_o[c] = raw_i[c];
    end else if (BIPOLAR) begin : g_sign
      assign ext_o[c] = {{PAD{raw_i[c][RES-1]}}, raw_i[c]};
    end else begin : g_zero
      assign ext_o[c] = {{PAD{1'b0}}, raw_i[c]};
    end
  end
endmodule

// File: rtl/scan_ctl.sv
module scan_ctl #(
  parameter int NCH = 16,
  parameter int GRP = 8,
  parameter int GSW = 1,
  parameter int IW  = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           stb_i,
  input  logic           scan_i,
  input  logic [GSW-1:0] grp_i,
  output logic           busy_o,
  output logic [IW-1:0]  idx_o,
  output logic           overrun_o
);
  localparam int NGRP = NCH / GRP;

  logic [IW:0] nwords;

  always_comb begin
    if (int'(grp_i) >= NGRP - 1) nwords = (IW+1)'(NCH / 2);
    else                         nwords = (IW+1)'((int'(grp_i) + 1) * (GRP / 2));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o    <= 1'b0;
      idx_o     <= '0;
      overrun_o <= 1'b0;
    end else begin
      if (stb_i && scan_i && busy_o) overrun_o <= 1'b1;
      if (busy_o) begin
        if ({1'b0, idx_o} == nwords - 1'b1) begin
          busy_o <= 1'b0;
          idx_o  <= '0;
        end else begin
          idx_o <= idx_o + 1'b1;
        end
      end else if (stb_i && scan_i && nwords > 1) begin
        busy_o <= 1'b1;
        idx_o  <= IW'(1);
      end
    end
  end

  // R8: once raised, overrun holds until reset
  assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    overrun_o |=> overrun_o);
  // R8: overrun only rises after a scan strobe met a pending scan
  assert_overrun_cause_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun_o) |-> $past(stb_i && scan_i && busy_o));
  // R5: the pending word index stays inside the active word count
  assert_idx_bound_R5: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> ({1'b0, idx_o} < nwords));
endmodule

// File: rtl/sample_packer.sv
module sample_packer
  import packer_pkg::*;
#(
  parameter int NCH     = 16,
  parameter int RES     = 12,
  parameter bit BIPOLAR = 1'b1,
  parameter int GRP     = 8,
  localparam int PSW    = $clog2(NCH / 2),
  localparam int GSW    = (NCH / GRP > 1) ? $clog2(NCH / GRP) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   smp_stb,
  input  logic [NCH*RES-1:0]     smp_data,
  input  logic [1:0]             pack_mode,
  input  logic [PSW-1:0]         pair_sel,
  input  logic [GSW-1:0]         grp_sel,
  input  logic                   mark_n,
  output logic [31:0]            wr_data,
  output logic                   wr_en,
  output logic                   overrun
);
  localparam int IW = PSW;

  pack_mode_e              md;
  logic [NCH-1:0][15:0]    ext;
  logic [NCH-1:0][15:0]    cap;
  logic                    cap_mk;
  logic                    mark_s;
  logic                    busy;
  logic [IW-1:0]           idx;
  logic                    phase;
  logic [15:0]             solo_lo;
  logic                    solo_mk;

  assign md = pack_mode_e'(pack_mode);

  mark_sync u_sync (
    .clk      (clk),
    .rst      (rst),
    .mark_n_i (mark_n),
    .mark_o   (mark_s)
  );

  chan_fmt #(.NCH(NCH), .RES(RES), .BIPOLAR(BIPOLAR)) u_fmt (
    .raw_i (smp_data),
    .ext_o (ext)
  );

  scan_ctl #(.NCH(NCH), .GRP(GRP), .GSW(GSW), .IW(IW)) u_scan (
    .clk       (clk),
    .rst       (rst),
    .stb_i     (smp_stb),
    .scan_i    (md == PK_SCAN),
    .grp_i     (grp_sel),
    .busy_o    (busy),
    .idx_o     (idx),
    .overrun_o (overrun)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en   <= 1'b0;
      wr_data <= '0;
      phase   <= 1'b0;
      solo_lo <= '0;
      solo_mk <= 1'b0;
      cap     <= '0;
      cap_mk  <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (md != PK_SOLO) phase <= 1'b0;
      if (busy) begin
        wr_en   <= 1'b1;
        wr_data <= make_word(cap[{idx, 1'b0}], cap[{idx, 1'b1}], cap_mk);
      end else if (smp_stb) begin
        unique case (md)
          PK_SCAN: begin
            cap     <= ext;
            cap_mk  <= mark_s;
            wr_en   <= 1'b1;
            wr_data <= make_word(ext[0], ext[1], mark_s);
          end
          PK_SOLO: begin
            if (!phase) begin
              solo_lo <= ext[0];
              solo_mk <= mark_s;
              phase   <= 1'b1;
            end else begin
              wr_en   <= 1'b1;
              wr_data <= make_word(solo_lo, ext[0], solo_mk | mark_s);
              phase   <= 1'b0;
            end
          end
          default: begin
            wr_en   <= 1'b1;
            wr_data <= make_word(ext[{pair_sel, 1'b0}], ext[{pair_sel, 1'b1}], mark_s);
          end
        endcase
      end
    end
  end

  // R3: an idle pair-mode strobe always yields a write on the next cycle
  assert_pair_write_R3: assert property (@(posedge clk) disable iff (rst)
    (smp_stb && !busy && (md == PK_PAIR || md == PK_ALT)) |=> wr_en);
  // R6: the first strobe of a solo pair only holds the sample
  assert_solo_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (smp_stb && !busy && md == PK_SOLO && !phase) |=> !wr_en);
endmodule

// File: tb/sim_sample_packer.sv
module sim_sample_packer;
  localparam int NCH = 16;
  localparam int RES = 12;

  logic clk = 1'b0, rst = 1'b1, stb = 1'b0, mark_n = 1'b1;
  logic [1:0] mode = 2'd0;
  logic [2:0] psel = 3'd0;
  logic [0:0] gsel = 1'b0;
  logic [NCH-1:0][RES-1:0] chv;
  logic [31:0] wd;
  logic we, ovr;
  int errs = 0, checks = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  sample_packer u0 (
    .clk(clk), .rst(rst), .smp_stb(stb), .smp_data(chv), .pack_mode(mode),
    .pair_sel(psel), .grp_sel(gsel), .mark_n(mark_n),
    .wr_data(wd), .wr_en(we), .overrun(ovr)
  );

  function automatic logic [15:0] ext16(logic [RES-1:0] v);
    return {{(16-RES){v[RES-1]}}, v};
  endfunction

  function automatic logic [31:0] expw(logic [RES-1:0] lo, logic [RES-1:0] hi, logic mk);
    logic [15:0] h;
    h = ext16(hi);
    return {h[15] | mk, h[14:0], ext16(lo)};
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic push(logic [31:0] w, string tag);
    exp_q.push_back(w);
    tag_q.push_back(tag);
  endtask

  // monitor: pops the scoreboard on every write
  always @(negedge clk) begin
    if (!rst && we) begin
      if (exp_q.size() == 0) begin
        chk(0, "R3/R4/R6/R8 unexpected write", wd, 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(wd === e, t, wd, e);
      end
    end
  end

  task automatic strobe();
    @(posedge clk); #1 stb = 1'b1;
    @(posedge clk); #1 stb = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic set_bus(int seed);
    for (int c = 0; c < NCH; c++) chv[c] = 12'(seed * 733 + c * 2311 + 5);
  endtask

  task automatic drain(string tag);
    idle(12);
    chk(exp_q.size() == 0, tag, 32'(exp_q.size()), 32'h0);
  endtask

  task automatic scan(int nw, logic mk, string tag);
    for (int k = 0; k < nw; k++) push(expw(chv[2*k], chv[2*k+1], mk), tag);
    strobe();
    set_bus(99);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errs++; checks++;
      $display("FAIL R9 watchdog act=hung exp=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    set_bus(1);
    idle(4);
    @(negedge clk);
    chk(we == 1'b0, "R9 wr_en in reset", 32'(we), 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk(we == 1'b0 && ovr == 1'b0, "R9 outputs after reset", {30'h0, ovr, we}, 32'h0);
    chk(wd == 32'h0, "R9 data after reset", wd, 32'h0);

    // R1 R2 R3: pair mode, several pairs and patterns
    mode = 2'd0;
    for (int p = 0; p < 8; p += 3) begin
      psel = 3'(p);
      set_bus(p + 2);
      push(expw(chv[2*p], chv[2*p+1], 1'b0), "R1 R2 R3 pair word");
      strobe();
      chk(we == 1'b1, "R3 write one cycle after strobe", 32'(we), 32'h1);
    end
    chv[0] = 12'h800; chv[1] = 12'h7FF; psel = 3'd0;
    push(expw(chv[0], chv[1], 1'b0), "R2 extremes");
    strobe();
    mode = 2'd3; psel = 3'd5; set_bus(7);
    push(expw(chv[10], chv[11], 1'b0), "R3 mode 3 acts as pair");
    strobe();
    drain("R3 pair queue drained");

    // R4 R5: scan of 8 channels, back-to-back at the scan length
    mode = 2'd1; gsel = 1'b0; set_bus(11);
    scan(4, 1'b0, "R4 scan 8ch");
    idle(2);
    set_bus(12);
    scan(4, 1'b0, "R4 second scan wraps to pair 0");
    drain("R4 scan queue drained");
    chk(ovr == 1'b0, "R8 no overrun at exact spacing", 32'(ovr), 32'h0);

    // R5: 16 active channels
    gsel = 1'b1; set_bus(21);
    scan(8, 1'b0, "R5 scan 16ch");
    drain("R5 scan queue drained");

    // R7: marker tags a whole scan, then a pair word, then clears
    gsel = 1'b0; set_bus(31);
    mark_n = 1'b0; idle(3);
    scan(4, 1'b1, "R7 marker on scan");
    drain("R7 scan drained");
    mode = 2'd0; psel = 3'd2; set_bus(32);
    push(expw(chv[4], chv[5], 1'b1), "R7 marker on pair");
    strobe();
    mark_n = 1'b1; idle(4);
    chv[5] = 12'h123;
    push(expw(chv[4], chv[5], 1'b0), "R7 marker released");
    strobe();
    drain("R7 pair drained");

    // R6: solo mode packs two channel-0 samples
    mode = 2'd2; idle(2);
    chv[0] = 12'h0A5; strobe();
    idle(1);
    chk(we == 1'b0 && exp_q.size() == 0, "R6 first strobe writes nothing", 32'(we), 32'h0);
    begin
      logic [RES-1:0] first;
      first = chv[0];
      chv[0] = 12'hF3C;
      push(expw(first, chv[0], 1'b0), "R6 solo word");
      strobe();
      chv[0] = 12'h311; strobe();
      first = chv[0];
      mark_n = 1'b0; idle(3);
      chv[0] = 12'h022;
      push(expw(first, chv[0], 1'b1), "R6 R7 solo marked on second sample");
      strobe();
      mark_n = 1'b1; idle(4);
    end
    drain("R6 solo drained");

    // R8: strobe two cycles into an 8ch scan is dropped
    mode = 2'd1; gsel = 1'b0; set_bus(41);
    scan(4, 1'b0, "R8 accepted scan");
    strobe();
    chk(ovr == 1'b1, "R8 overrun set", 32'(ovr), 32'h1);
    drain("R8 dropped scan wrote nothing");
    idle(20);
    chk(ovr == 1'b1, "R8 overrun sticky", 32'(ovr), 32'h1);

    // R9: reset clears the flag
    rst = 1'b1; idle(2); rst = 1'b0;
    @(negedge clk);
    chk(ovr == 1'b0 && we == 1'b0, "R9 reset clears overrun", {30'h0, ovr, we}, 32'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule